// File: doc/BRIEF.md
# Column Slope-Ratio Self-Calibration Controller

This block runs once per column at power-up, before any frame is captured. It matches the gain of the fine ramp to the gain of the coarse ramp. It does this by closing a digital loop around an analog transconductance trim. A start pulse loads a mid-scale trim code. The controller then asks the column converter for two conversions, placed at the bottom and at the top of the fine range inside one coarse step. It subtracts the two codes and compares the result with the ideal fine span of 127 codes. It then moves the trim code one step toward the ideal.

The loop stops in any of these cases:
- The span is exactly right. This is a success.
- The wanted step direction flips between two iterations, which means the ideal has been straddled. This is a success.
- A step would push the trim code past either end of its range. This is a failure.
- An iteration budget runs out. This is a failure.

The converter and the trim DAC sit outside the block. The converter is reached through a request/ready handshake. The trim DAC takes the trim code as a plain bus.

Top module: `col_gain_trim_ctrl`

## Requirements
- R1: A `cal_start` pulse sampled while the block is idle or finished loads the trim code with its default of 64 and clears both flags. The first conversion request appears in the next cycle. Reset leaves the trim at 64, both flags low and no request pending.
- R2: Each iteration requests the low point first (`conv_point`=0), then the high point (`conv_point`=1). A request and its point select stay unchanged until `conv_ready` is high. `conv_code` is captured in the cycle that `conv_ready` is high.
- R3: The measured span is the high code minus the low code, treated as a signed value. When it equals 127, `cal_done` rises and the trim code does not move.
- R4: A span below 127 increments the trim code by one. A span above 127 decrements it by one. A new iteration then starts. The trim code changes by at most one per cycle, except when a start reloads it.
- R5: When the step direction wanted in an iteration is the opposite of the step taken in the previous iteration, `cal_done` rises and the trim code keeps its current value.
- R6: When a step is wanted beyond 127 or below 0, `cal_fail` rises and the trim code stays at that rail. It never wraps.
- R7: When MAX_ITER (default 128) evaluations pass without a successful end, `cal_fail` rises at the last one without a further step. A match or a reversal in that same evaluation still counts as success.
- R8: After either flag rises, no request is issued and the flags and trim code hold until the next start. A start pulse during a run is ignored. The two flags are never high together.
- R9: Against a column whose span rises by 1 to 2 codes per trim step, a successful run ends with the span at the final trim code within one code of 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_start | input | 1 | Start pulse for a calibration run |
| conv_req | output | 1 | Conversion request to the column converter |
| conv_point | output | 1 | 0 selects the lowest fine point, 1 selects the highest |
| conv_ready | input | 1 | Conversion finished; `conv_code` is valid |
| conv_code | input | CODE_W (9) | Converted code |
| trim_code | output | TRIM_W (7) | Trim code to the transconductance DAC |
| cal_done | output | 1 | Calibration converged |
| cal_fail | output | 1 | Calibration gave up (rail or iteration limit) |

## Verification
Results become visible at set edges:
- The trim reload and the first request become visible one edge after the start is sampled.
- Each code is captured at the edge where `conv_ready` is high.
- The evaluation takes one more edge after the high-point capture, and the flags and any trim step appear there together.

The bench drives and samples on falling edges. For each run it waits for a flag and only then compares the trim code, the status and the number of conversions. The expected values come from a bench function that applies the stopping rules to a linear column model. The column model answers requests after a random delay of 0 to 2 cycles, so the handshake wait is exercised at every point.

// File: rtl/cal_pkg.sv
// Shared types for the column calibration controller.
package cal_pkg;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ_LO,
        ST_REQ_HI,
        ST_EVAL,
        ST_END
    } cal_state_e;

    // Direction of the last trim step.
    typedef enum logic [1:0] {
        DIR_NONE,
        DIR_UP,
        DIR_DN
    } step_dir_e;

endpackage

// File: rtl/gain_trim_reg.sv
// Saturating trim register.
// Loads the default code on request and steps by one toward either end.
// A step past either rail is dropped.
// Assumes at most one of load/up/dn matters per cycle; load wins.
module gain_trim_reg #(
    parameter int TRIM_W       = 7,
    parameter int TRIM_DEFAULT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step_up,
    input  logic              step_dn,
    output logic [TRIM_W-1:0] trim,
    output logic              at_max,
    output logic              at_min
);
    localparam logic [TRIM_W-1:0] DEF_CODE = TRIM_W'(TRIM_DEFAULT);
    localparam logic [TRIM_W-1:0] TOP_CODE = {TRIM_W{1'b1}};

    // Holds the trim code; the update is saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                          trim <= DEF_CODE;
        else if (load)                       trim <= DEF_CODE;
        else if (step_up && trim != TOP_CODE) trim <= trim + 1'b1;
        else if (step_dn && trim != '0)       trim <= trim - 1'b1;
    end

    // Rail flags for the sequencer.
    always_comb begin
        at_max = (trim == TOP_CODE);
        at_min = (trim == '0);
    end

    // Unit step only, so no wrap (R4, R6).
    assert_trim_unit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (trim == $past(trim) || trim == $past(trim) + 1 || trim == $past(trim) - 1));

endmodule

// File: rtl/span_capture.sv
// Stores the low-point and high-point codes and compares their difference
// with the ideal fine span.
// The difference is signed, so a high code below the low code reads as a short span.
module span_capture #(
    parameter int CODE_W     = 9,
    parameter int IDEAL_SPAN = 127
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_lo,
    input  logic              cap_hi,
    input  logic [CODE_W-1:0] code,
    output logic              below,
    output logic              above
);
    localparam int DIFF_W = CODE_W + 1;
    localparam logic signed [DIFF_W-1:0] IDEAL = DIFF_W'(IDEAL_SPAN);

    logic [CODE_W-1:0]        lo_q;
    logic [CODE_W-1:0]        hi_q;
    logic signed [DIFF_W-1:0] span;

    // Captures the two measurement codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (cap_lo) lo_q <= code;
            if (cap_hi) hi_q <= code;
        end
    end

    // Signed difference and comparison with the ideal span.
    always_comb begin
        span  = $signed({1'b0, hi_q}) - $signed({1'b0, lo_q});
        below = (span < IDEAL);
        above = (span > IDEAL);
    end

    // Only one point is measured at a time (R2).
    assert_single_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_lo && cap_hi));

endmodule

// File: rtl/cal_sequencer.sv
// Calibration sequencer.
// Orders the two conversions, evaluates the span and decides whether to
// step, finish or fail.
// Assumes the span compare inputs are valid in ST_EVAL.
module cal_sequencer
    import cal_pkg::*;
#(
    parameter int MAX_ITER = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic conv_ready,
    input  logic below,
    input  logic above,
    input  logic at_max,
    input  logic at_min,
    output logic conv_req,
    output logic conv_point,
    output logic cap_lo,
    output logic cap_hi,
    output logic trim_load,
    output logic trim_up,
    output logic trim_dn,
    output logic done_o,
    output logic fail_o
);
    localparam int ITER_W = $clog2(MAX_ITER + 1);
    localparam logic [ITER_W-1:0] LAST_ITER = ITER_W'(MAX_ITER - 1);

    cal_state_e        state;
    step_dir_e         prev_dir;
    step_dir_e         want_dir;
    logic [ITER_W-1:0] iter_cnt;
    logic              launch, is_eval, reversed, blocked;
    logic              finish_ok, finish_bad, take_step;

    // Handshake and capture strobes.
    always_comb begin
        conv_req   = (state == ST_REQ_LO) || (state == ST_REQ_HI);
        conv_point = (state == ST_REQ_HI);
        cap_lo     = (state == ST_REQ_LO) && conv_ready;
        cap_hi     = (state == ST_REQ_HI) && conv_ready;
        launch     = start && ((state == ST_IDLE) || (state == ST_END));
        trim_load  = launch;
    end

    // Evaluation decision: match, reversal, budget, rail, then step.
    always_comb begin
        is_eval    = (state == ST_EVAL);
        want_dir   = below ? DIR_UP : DIR_DN;
        reversed   = (prev_dir != DIR_NONE) && (want_dir != prev_dir);
        blocked    = (want_dir == DIR_UP) ? at_max : at_min;
        finish_ok  = is_eval && ((!below && !above) || reversed);
        finish_bad = is_eval && !finish_ok && ((iter_cnt == LAST_ITER) || blocked);
        take_step  = is_eval && !finish_ok && !finish_bad;
        trim_up    = take_step && (want_dir == DIR_UP);
        trim_dn    = take_step && (want_dir == DIR_DN);
    end

    // State, iteration count, last direction and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            prev_dir <= DIR_NONE;
            iter_cnt <= '0;
            done_o   <= 1'b0;
            fail_o   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE, ST_END: if (launch) begin
                    state    <= ST_REQ_LO;
                    prev_dir <= DIR_NONE;
                    iter_cnt <= '0;
                    done_o   <= 1'b0;
                    fail_o   <= 1'b0;
                end
                ST_REQ_LO: if (conv_ready) state <= ST_REQ_HI;
                ST_REQ_HI: if (conv_ready) state <= ST_EVAL;
                ST_EVAL: begin
                    if (take_step) begin
                        state    <= ST_REQ_LO;
                        prev_dir <= want_dir;
                        iter_cnt <= iter_cnt + 1'b1;
                    end else begin
                        state  <= ST_END;
                        done_o <= finish_ok;
                        fail_o <= finish_bad;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Request and point held until accepted (R2).
    assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && !conv_ready) |=> (conv_req && $stable(conv_point)));

    // Quiet after a result (R8).
    assert_quiet_after_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || fail_o) |-> !conv_req);

    // Flags exclusive (R8).
    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o));

    // Budget never exceeded (R7).
    assert_iter_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        iter_cnt < ITER_W'(MAX_ITER));

endmodule

// File: rtl/col_gain_trim_ctrl.sv
// Column slope-ratio calibration controller top.
// Ties the sequencer, the span capture and the trim register together.
// Assumes the converter holds conv_code valid while conv_ready is high.
module col_gain_trim_ctrl #(
    parameter int TRIM_W       = 7,
    parameter int CODE_W       = 9,
    parameter int IDEAL_SPAN   = 127,
    parameter int TRIM_DEFAULT = 64,
    parameter int MAX_ITER     = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_start,
    output logic              conv_req,
    output logic              conv_point,
    input  logic              conv_ready,
    input  logic [CODE_W-1:0] conv_code,
    output logic [TRIM_W-1:0] trim_code,
    output logic              cal_done,
    output logic              cal_fail
);
    logic cap_lo, cap_hi, below, above;
    logic trim_load, trim_up, trim_dn, at_max, at_min;

    cal_sequencer #(.MAX_ITER(MAX_ITER)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cal_start),
        .conv_ready(conv_ready),
        .below     (below),
        .above     (above),
        .at_max    (at_max),
        .at_min    (at_min),
        .conv_req  (conv_req),
        .conv_point(conv_point),
        .cap_lo    (cap_lo),
        .cap_hi    (cap_hi),
        .trim_load (trim_load),
        .trim_up   (trim_up),
        .trim_dn   (trim_dn),
        .done_o    (cal_done),
        .fail_o    (cal_fail)
    );

    span_capture #(.CODE_W(CODE_W), .IDEAL_SPAN(IDEAL_SPAN)) u_span (
        .clk   (clk),
        .rst_n (rst_n),
        .cap_lo(cap_lo),
        .cap_hi(cap_hi),
        .code  (conv_code),
        .below (below),
        .above (above)
    );

    gain_trim_reg #(.TRIM_W(TRIM_W), .TRIM_DEFAULT(TRIM_DEFAULT)) u_trim (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (trim_load),
        .step_up(trim_up),
        .step_dn(trim_dn),
        .trim   (trim_code),
        .at_max (at_max),
        .at_min (at_min)
    );

endmodule

// File: tb/test_col_gain_trim_ctrl.sv
// Bench: two instances with linear column models.
// The short-budget instance reaches the iteration limit.
module test_col_gain_trim_ctrl;
    localparam int SHORT_ITER = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic       start_a = 1'b0, rdy_a = 1'b0, req_a, pt_a, done_a, fail_a;
    logic [8:0] code_a = '0;
    logic [6:0] trim_a;
    logic       start_b = 1'b0, rdy_b = 1'b0, req_b, pt_b, done_b, fail_b;
    logic [8:0] code_b = '0;
    logic [6:0] trim_b;

    col_gain_trim_ctrl i_col_gain_trim_ctrl (
        .clk(clk), .rst_n(rst_n), .cal_start(start_a), .conv_req(req_a),
        .conv_point(pt_a), .conv_ready(rdy_a), .conv_code(code_a),
        .trim_code(trim_a), .cal_done(done_a), .cal_fail(fail_a));

    col_gain_trim_ctrl #(.MAX_ITER(SHORT_ITER)) i_col_gain_trim_ctrl_short (
        .clk(clk), .rst_n(rst_n), .cal_start(start_b), .conv_req(req_b),
        .conv_point(pt_b), .conv_ready(rdy_b), .conv_code(code_b),
        .trim_code(trim_b), .cal_done(done_b), .cal_fail(fail_b));

    int checks = 0, errors = 0, cyc = 0;
    int off_a = 0, off_b = 0;
    int conv_a = 0, conv_b = 0, ord_err_a = 0, ord_err_b = 0;
    int wait_a = 0, wait_b = 0, lo_a = 0, lo_b = 0;
    bit exp_pt_a = 1'b0, exp_pt_b = 1'b0;

    // Column span grows 1.5 codes per trim step.
    function automatic int span_of(input int off, input int t);
        return off + (3 * t) / 2;
    endfunction

    // Expected outcome from the stopping rules.
    function automatic void ref_run(input int off, input int max_iter,
                                    output int t, output int evals, output bit ok);
        int prev = 0;
        t = 64;
        evals = 0;
        ok = 1'b0;
        for (int n = 1; n <= max_iter; n++) begin
            int c = span_of(off, t);
            int d = (c < 127) ? 1 : -1;
            evals = n;
            if (c == 127) begin ok = 1'b1; return; end
            if (prev != 0 && d != prev) begin ok = 1'b1; return; end
            if (n == max_iter) return;
            if ((d == 1 && t == 127) || (d == -1 && t == 0)) return;
            t += d;
            prev = d;
        end
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Column model for the main instance.
    always @(negedge clk) begin
        if (rdy_a) begin
            rdy_a = 1'b0;
            wait_a = $urandom_range(0, 2);
        end else if (req_a) begin
            if (wait_a > 0) wait_a--;
            else begin
                if (pt_a !== exp_pt_a) ord_err_a++;
                if (!pt_a) begin
                    lo_a = $urandom_range(0, 150);
                    code_a = 9'(lo_a);
                end else code_a = 9'(lo_a + span_of(off_a, int'(trim_a)));
                rdy_a = 1'b1;
                conv_a++;
                exp_pt_a = ~exp_pt_a;
            end
        end
    end

    // Column model for the short-budget instance.
    always @(negedge clk) begin
        if (rdy_b) begin
            rdy_b = 1'b0;
            wait_b = $urandom_range(0, 2);
        end else if (req_b) begin
            if (wait_b > 0) wait_b--;
            else begin
                if (pt_b !== exp_pt_b) ord_err_b++;
                if (!pt_b) begin
                    lo_b = $urandom_range(0, 150);
                    code_b = 9'(lo_b);
                end else code_b = 9'(lo_b + span_of(off_b, int'(trim_b)));
                rdy_b = 1'b1;
                conv_b++;
                exp_pt_b = ~exp_pt_b;
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // One run on the main instance; the tag names the requirement for status.
    task automatic run_main(input int off, input string tag, input bit poke_mid);
        int et, ev;
        bit eok;
        ref_run(off, 128, et, ev, eok);
        off_a = off;
        conv_a = 0;
        ord_err_a = 0;
        exp_pt_a = 1'b0;
        @(negedge clk) start_a = 1'b1;
        @(negedge clk) start_a = 1'b0;
        check(trim_a == 7'd64 && !done_a && !fail_a && req_a, "R1 start load", int'(trim_a), 64);
        if (poke_mid) begin
            repeat (7) @(negedge clk);
            start_a = 1'b1;
            @(negedge clk) start_a = 1'b0;
        end
        for (int i = 0; i < 20000 && !(done_a || fail_a); i++) @(negedge clk);
        check(done_a == eok && fail_a == !eok, {tag, " status"}, int'(done_a), int'(eok));
        check(int'(trim_a) == et, "R4 final trim", int'(trim_a), et);
        check(conv_a == 2 * ev, "R2 conversion count", conv_a, 2 * ev);
        check(ord_err_a == 0, "R2 point order", ord_err_a, 0);
        if (eok) begin
            int s = span_of(off, int'(trim_a));
            check(s >= 126 && s <= 128, "R9 within one code", s, 127);
        end
        repeat (10) @(negedge clk);
        check(conv_a == 2 * ev && !req_a && int'(trim_a) == et && (done_a || fail_a),
              "R8 hold after end", conv_a, 2 * ev);
    endtask

    initial begin
        int et, ev, mode;
        bit eok;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R1: reset state.
        check(trim_a == 7'd64 && !req_a && !done_a && !fail_a, "R1 reset", int'(trim_a), 64);
        rst_n = 1'b1;
        @(negedge clk);

        run_main(31, "R3 exact match", 1'b0);     // span 127 at the default trim
        run_main(29, "R5 reversal", 1'b0);        // 125,126,128: stops at trim 66
        run_main(-100, "R6 upper rail", 1'b0);    // always short: fails at 127
        run_main(200, "R6 lower rail", 1'b0);     // always long: fails at 0
        run_main(127 - 90, "R8 start ignored", 1'b1);
        for (int k = 0; k < 12; k++) begin
            int tt = $urandom_range(5, 122);
            run_main(127 - (3 * tt) / 2 + int'($urandom_range(0, 1)), "R4 random", 1'b0);
        end

        // R7: iteration limit on the short-budget instance.
        off_b = -100;
        ref_run(off_b, SHORT_ITER, et, ev, eok);
        @(negedge clk) start_b = 1'b1;
        @(negedge clk) start_b = 1'b0;
        for (int i = 0; i < 2000 && !(done_b || fail_b); i++) @(negedge clk);
        check(fail_b && !done_b && !eok, "R7 limit status", int'(fail_b), 1);
        check(int'(trim_b) == et, "R7 limit trim", int'(trim_b), et);
        check(conv_b == 2 * ev, "R7 conversions", conv_b, 2 * ev);
        check(ord_err_b == 0, "R2 point order short", ord_err_b, 0);
        mode = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors + mode);
        $finish;
    end
endmodule